// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Almost Flags

This block is a first-in first-out buffer of 64 words of 36 bits that joins a producer and a consumer running on separate clocks, which may be unrelated in phase and frequency. Each side has its own active-low select and active-high enable. A word moves only on a rising edge of that side's clock when both are asserted and the side's blocking flag allows it.

Each side reports on its own clock. The read side has an active-low empty flag and an active-low almost-empty flag. The write side has an active-low full flag and an active-low almost-full flag. Both almost flags compare against one threshold X. A two-bit select input picks X from four presets, and the block captures the select while reset is held. Pointers cross between the clock domains in Gray code through two-flop synchronizers. For this reason a flag that depends on the far side changes two local clock edges after the event on the far side.

Top module: `dcfifo_pflags`

## Requirements
- R1: A write happens on a rising `wclk` edge only when `wr_cs_n`=0, `wr_en`=1 and `full_n`=1 at that edge. A read happens on a rising `rclk` edge only when `rd_cs_n`=0, `rd_en`=1 and `empty_n`=1. Under any other input combination the stored contents and the flags stay unchanged.
- R2: Each accepted read loads `rd_data` on that `rclk` edge with the oldest stored word, so words leave in the order they were written. `rd_data` holds its value on every edge that performs no read.
- R3: `empty_n` is 0 after any `rclk` edge at which `rst_n`=0. It is 1 from the second `rclk` edge after a write into an empty FIFO. It is 0 whenever the read side sees no stored words.
- R4: `full_n` is 0 after any `wclk` edge at which `rst_n`=0. With the FIFO not full, it returns to 1 on the second `wclk` edge after reset is released. It is 0 while the write side sees 64 stored words, and it returns to 1 on the second `wclk` edge after a read frees a location.
- R5: `almost_empty_n` is 0 exactly when the word count seen by the read side is less than or equal to X.
- R6: `almost_full_n` is 0 exactly when the free-location count seen by the write side (64 minus the stored words seen there) is less than or equal to X.
- R7: X = 16 − 4·`off_sel`, which gives 16, 12, 8 and 4 for codes 0, 1, 2 and 3. The value used is the one present at the last clock edge with `rst_n`=0. Changes to `off_sel` after reset is released have no effect.
- R8: A write attempted while `full_n`=0 is dropped and overwrites nothing. A read attempted while `empty_n`=0 is dropped and leaves `rd_data` unchanged.
- R9: The reset is active low and synchronous to each clock. It clears both pointers and sets `rd_data` to 0. It must be held for at least two edges of each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| off_sel | input | 2 | Threshold preset code, captured while reset is held |
| wr_cs_n | input | 1 | Write-side select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when full or in reset start-up |
| almost_full_n | output | 1 | Low when free locations ≤ X |
| rd_cs_n | input | 1 | Read-side select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 36 | Last word read |
| empty_n | output | 1 | Low when empty |
| almost_empty_n | output | 1 | Low when stored words ≤ X |

## Verification
The assertions assume that `rst_n` stays low for at least two edges of each clock, so every pointer and synchronizer register is defined before a disable condition lifts. They also assume that inputs settle well away from the edges of their own clock. The bench meets both assumptions by holding reset for three cycles and by driving every input on the falling edge. Both ports run from one 125 MHz clock, which is the coincident case the block allows. With that clock each two-edge crossing happens on a known cycle, and the arithmetic model can predict every flag on every cycle for all four threshold codes.

// File: rtl/dcf_pkg.sv
// Shared helpers for the dual-clock FIFO: Gray conversion and the
// threshold preset table. Assumes pointer widths of at most 32 bits.
package dcf_pkg;

    localparam int OFF_BASE = 16;   // threshold for select code 0
    localparam int OFF_STEP = 4;    // decrement per select code step

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray code back to binary by prefix XOR.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        b = b ^ (b >> 1);
        b = b ^ (b >> 2);
        b = b ^ (b >> 4);
        b = b ^ (b >> 8);
        b = b ^ (b >> 16);
        return b;
    endfunction

    // Threshold selected by a two-bit code.
    function automatic logic [31:0] preset_offset(input logic [1:0] sel);
        return 32'(OFF_BASE) - 32'(OFF_STEP) * {30'd0, sel};
    endfunction

endpackage

// File: rtl/dcf_sync.sv
// Two-flop synchronizer for a Gray-coded pointer bus.
// Assumes the source changes at most one bit per source clock edge.
module dcf_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture of the foreign pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
// Storage array with one write port and one registered read port.
// Assumes the controls never address a word that is being written.
module dcf_mem #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Load the output register on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcf_wr_side.sv
// Write-side control: write pointer, full and almost-full flags, and
// the captured threshold. Assumes rgray_s comes through a synchronizer.
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic [1:0]    off_sel,
    input  logic          cs_n,
    input  logic          en,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          wfire,
    output logic          full_n,
    output logic          almost_full_n
);
    localparam int PW    = AW + 1;
    localparam int OW    = AW + 2;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin, wbin_nxt, rbin_w, used;
    logic [OW-1:0] free, offset_q;
    logic [1:0]    init_sr;

    // Capture the threshold while reset is held.
    always_ff @(posedge wclk) begin
        if (!rst_n) offset_q <= OW'(preset_offset(off_sel));
    end

    // Two-edge start-up delay before the full flag may release.
    always_ff @(posedge wclk) begin
        if (!rst_n) init_sr <= 2'b00;
        else        init_sr <= {init_sr[0], 1'b1};
    end

    assign wbin_nxt = wbin + PW'(wfire);

    // Binary and Gray write pointers.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= PW'(to_gray(32'(wbin_nxt)));
        end
    end

    // Occupancy as seen on this side and the derived flags.
    always_comb begin
        rbin_w        = PW'(from_gray(32'(rgray_s)));
        used          = wbin - rbin_w;
        free          = OW'(DEPTH) - {1'b0, used};
        full_n        = init_sr[1] & (used != PW'(DEPTH));
        almost_full_n = !(free <= offset_q);
        wfire         = !cs_n & en & full_n;
        waddr         = wbin[AW-1:0];
    end
endmodule

// File: rtl/dcf_rd_side.sv
// Read-side control: read pointer, empty and almost-empty flags, and
// the captured threshold. Assumes wgray_s comes through a synchronizer.
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [1:0]    off_sel,
    input  logic          cs_n,
    input  logic          en,
    input  logic [AW:0]   wgray_s,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic          rfire,
    output logic          empty_n,
    output logic          almost_empty_n
);
    localparam int PW = AW + 1;
    localparam int OW = AW + 2;

    logic [PW-1:0] rbin, rbin_nxt, wbin_r, cnt;
    logic [OW-1:0] offset_q;

    // Capture the threshold while reset is held.
    always_ff @(posedge rclk) begin
        if (!rst_n) offset_q <= OW'(preset_offset(off_sel));
    end

    assign rbin_nxt = rbin + PW'(rfire);

    // Binary and Gray read pointers.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= PW'(to_gray(32'(rbin_nxt)));
        end
    end

    // Word count as seen on this side and the derived flags.
    always_comb begin
        wbin_r         = PW'(from_gray(32'(wgray_s)));
        cnt            = wbin_r - rbin;
        empty_n        = (cnt != '0);
        almost_empty_n = !({1'b0, cnt} <= offset_q);
        rfire          = !cs_n & en & empty_n;
        raddr          = rbin[AW-1:0];
    end
endmodule

// File: rtl/dcfifo_pflags.sv
// Top level of the dual-clock FIFO with preset almost flags.
// Assumes rst_n is held for at least two edges of each clock.
module dcfifo_pflags #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [1:0]    off_sel,
    input  logic          wr_cs_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full_n,
    output logic          almost_full_n,
    input  logic          rd_cs_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          almost_empty_n
);
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic          wfire, rfire;

    dcf_wr_side #(.AW(AW)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .off_sel(off_sel),
        .cs_n(wr_cs_n), .en(wr_en), .rgray_s(rgray_s),
        .wgray(wgray), .waddr(waddr), .wfire(wfire),
        .full_n(full_n), .almost_full_n(almost_full_n)
    );

    dcf_rd_side #(.AW(AW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .off_sel(off_sel),
        .cs_n(rd_cs_n), .en(rd_en), .wgray_s(wgray_s),
        .rgray(rgray), .raddr(raddr), .rfire(rfire),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );

    dcf_sync #(.W(AW + 1)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(AW + 1)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_mem #(.AW(AW), .DW(DW)) u_mem (
        .wclk(wclk), .we(wfire), .waddr(waddr), .wdata(wr_data),
        .rclk(rclk), .rst_n(rst_n), .re(rfire), .raddr(raddr),
        .rdata(rd_data)
    );
endmodule

// File: rtl/dcfifo_pflags_chk.sv
// Property checker for dcfifo_pflags, attached with bind.
// Assumes reset is held for at least two edges of each clock.
module dcfifo_pflags_chk #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_cs_n,
    input logic          wr_en,
    input logic          rd_cs_n,
    input logic          rd_en,
    input logic          full_n,
    input logic          empty_n,
    input logic          almost_empty_n,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rgray,
    input logic [DW-1:0] rd_data
);
    assert_empty_in_reset_R3: assert property (@(posedge rclk)
        !rst_n |=> !empty_n);

    assert_full_in_reset_R4: assert property (@(posedge wclk)
        !rst_n |=> !full_n);

    assert_no_write_unselected_R1: assert property (@(posedge wclk)
        disable iff (!rst_n) (wr_cs_n || !wr_en) |=> $stable(wgray));

    assert_no_overflow_R8: assert property (@(posedge wclk)
        disable iff (!rst_n) !full_n |=> $stable(wgray));

    assert_no_underflow_R8: assert property (@(posedge rclk)
        disable iff (!rst_n) !empty_n |=> $stable(rgray));

    assert_data_hold_R2: assert property (@(posedge rclk)
        disable iff (!rst_n) !(!rd_cs_n && rd_en && empty_n) |=> $stable(rd_data));

    assert_empty_implies_low_R5: assert property (@(posedge rclk)
        disable iff (!rst_n) !empty_n |-> !almost_empty_n);

    assert_wgray_one_bit_R1: assert property (@(posedge wclk)
        disable iff (!rst_n) $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_one_bit_R1: assert property (@(posedge rclk)
        disable iff (!rst_n) $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind dcfifo_pflags dcfifo_pflags_chk #(.AW(AW), .DW(DW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .rd_cs_n(rd_cs_n), .rd_en(rd_en),
    .full_n(full_n), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .wgray(wgray), .rgray(rgray), .rd_data(rd_data)
);

// File: tb/sim_dcfifo_pflags.sv
// Bench: both ports share one 125 MHz clock, the coincident case.
// An arithmetic model predicts every output on every cycle.
module sim_dcfifo_pflags;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    off_sel = 2'd0;
    logic          wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          full_n, almost_full_n, empty_n, almost_empty_n;
    logic [DW-1:0] rd_data;

    int vectors = 0;
    int fails   = 0;

    always #4 clk = ~clk;

    dcfifo_pflags u0 (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .off_sel(off_sel),
        .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data),
        .full_n(full_n), .almost_full_n(almost_full_n),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );

    // Model state.
    int            wp, rp, wp_s1, wp_s2, rp_s1, rp_s2, xoff;
    logic [1:0]    sr;
    logic [DW-1:0] mdl [64];
    logic [DW-1:0] e_rdata;
    logic          e_empty_n, e_ae_n, e_full_n, e_af_n;
    logic [15:0]   lfsr = 16'hACE1;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic void derive();
        int cr, used;
        cr        = (wp_s2 - rp) & 127;
        used      = (wp - rp_s2) & 127;
        e_empty_n = (cr != 0);
        e_ae_n    = (cr > xoff);
        e_full_n  = sr[1] && (used != 64);
        e_af_n    = ((64 - used) > xoff);
    endfunction

    // One clock cycle: inputs already set, model update, check at negedge.
    task automatic step();
        logic wacc, racc;
        @(posedge clk);
        if (!rst_n) begin
            wp = 0; rp = 0; wp_s1 = 0; wp_s2 = 0; rp_s1 = 0; rp_s2 = 0;
            sr = 2'b00; e_rdata = '0;
            xoff = 16 - 4 * int'(off_sel);
        end else begin
            wacc = !wr_cs_n && wr_en && e_full_n;
            racc = !rd_cs_n && rd_en && e_empty_n;
            if (racc) e_rdata = mdl[rp % 64];
            if (wacc) mdl[wp % 64] = wr_data;
            wp_s2 = wp_s1; wp_s1 = wp;
            rp_s2 = rp_s1; rp_s1 = rp;
            wp = (wp + int'(wacc)) & 127;
            rp = (rp + int'(racc)) & 127;
            sr = {sr[0], 1'b1};
        end
        derive();
        @(negedge clk);
        chk("R3 R1 empty_n", DW'(empty_n), DW'(e_empty_n));
        chk("R4 R8 full_n", DW'(full_n), DW'(e_full_n));
        chk("R5 R7 almost_empty_n", DW'(almost_empty_n), DW'(e_ae_n));
        chk("R6 R7 almost_full_n", DW'(almost_full_n), DW'(e_af_n));
        chk("R2 R8 rd_data", rd_data, e_rdata);
    endtask

    task automatic drive(input logic wc, input logic we, input logic rc, input logic re);
        wr_cs_n = wc; wr_en = we; rd_cs_n = rc; rd_en = re;
        wr_data = {lfsr, lfsr[7:0], lfsr, 4'h5};
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        for (int s = 0; s < 4; s++) begin
            off_sel = 2'(s);
            rst_n = 1'b0;
            drive(1'b0, 1'b1, 1'b0, 1'b1);
            for (int i = 0; i < 3; i++) step();
            // r9_: reset state
            chk("R9 rd_data cleared", rd_data, '0);
            chk("R9 empty_n low", DW'(empty_n), '0);
            chk("R9 full_n low", DW'(full_n), '0);
            rst_n = 1'b1;
            off_sel = ~2'(s);              // R7: ignored after release
            drive(1'b1, 1'b0, 1'b1, 1'b0);
            step();
            chk("R4 full_n after one edge", DW'(full_n), '0);
            step();
            chk("R4 full_n after two edges", DW'(full_n), DW'(1'b1));
            // Fill beyond capacity; extra writes must be dropped.
            for (int i = 0; i < 70; i++) begin drive(1'b0, 1'b1, 1'b1, 1'b0); step(); end
            chk("R8 full after overfill", DW'(full_n), '0);
            chk("R6 almost_full low when full", DW'(almost_full_n), '0);
            // Enabled but not selected: nothing moves.
            for (int i = 0; i < 5; i++) begin drive(1'b1, 1'b1, 1'b1, 1'b1); step(); end
            chk("R1 rd_data unchanged unselected", rd_data, '0);
            // Drain beyond empty; extra reads must be dropped.
            for (int i = 0; i < 70; i++) begin drive(1'b1, 1'b0, 1'b0, 1'b1); step(); end
            chk("R8 empty after overdrain", DW'(empty_n), '0);
            // Single write into empty FIFO: empty_n rises on 2nd edge.
            drive(1'b0, 1'b1, 1'b1, 1'b0); step();
            drive(1'b1, 1'b0, 1'b1, 1'b0); step();
            chk("R3 empty_n after one edge", DW'(empty_n), '0);
            step();
            chk("R3 empty_n after two edges", DW'(empty_n), DW'(1'b1));
            // Mixed pseudo-random traffic.
            for (int i = 0; i < 300; i++) begin
                drive(lfsr[0] & lfsr[5], lfsr[1] | lfsr[9], lfsr[2] & lfsr[7], lfsr[3] | (s[0] & lfsr[11]));
                step();
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule